// File: doc/BRIEF.md
# Retention-Binned Free Page Allocator

This block manages the free physical pages of a DRAM whose rows have been characterised for charge retention. Each page is loaded once, through an initialization port, with its measured retention class (a bin). Free pages sit on one list per bin. An allocation request always takes a page from the longest-retention bin that still holds a free page. A freed page goes back onto the list of its own bin.

The block counts occupied pages per bin. From these counts it reports one refresh period. That period is safe for every occupied page, because it is the lower retention bound of the weakest bin that currently holds an occupied page. The whole array is still refreshed at that period, and only the occupied pages need to survive it. Pages in the weakest retention class are marked as outliers at load time and never reach a list. System software is expected to program the refresh timer from the reported period.

Bins are numbered from 0, the longest retention, upward. With the default parameters there are ten bins. Each spans 4700 ms and the top bound is 50000 ms, so the lower bounds run from 45300 ms (bin 0) down to 3000 ms (bin 9).

Top module: `retention_page_alloc`

## Requirements
- R1: After reset no allocation response is pending, every list is empty (an allocation fails), and the reported period is the lower bound of bin 0 (45300 ms by default).
- R2: An init operation puts the page on the list of the bin it names. Bin k, counted from 0 as the longest retention, has a lower bound of MAX_MS-(k+1)*STEP_MS.
- R3: An init operation whose bin value is NUM_BINS or larger marks the page as an outlier. That page is never granted.
- R4: An allocation request gets exactly one response in the cycle after it: either allocGrant with allocPage, or allocFail. A grant is served from the lowest-numbered non-empty bin.
- R5: Within one bin, the page pushed most recently is granted first.
- R6: An allocation with every list empty raises allocFail and changes no state. The period is unchanged, and later grants are the same as if the request had never been made.
- R7: Freeing a page puts it at the head of its own bin's list, so the next grant from that bin returns it.
- R8: The reported period equals the lower bound of the highest-numbered bin with at least one occupied page, or the bin-0 bound when no page is occupied. It changes in the cycle after the alloc or free edge.
- R9: allocGrant and allocFail are never high together, and each is a one-cycle pulse per request.
- R10: A grant never raises the reported period, and a free never lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initValid | input | 1 | Load one page into the lists; takes precedence over the other requests |
| initPage | input | PAGE_W | Page index being loaded |
| initBin | input | BIN_W | Retention bin of that page; NUM_BINS or more means outlier |
| freeValid | input | 1 | Return an occupied page; takes precedence over allocReq |
| freePage | input | PAGE_W | Page index being returned |
| allocReq | input | 1 | Request one free page |
| allocGrant | output | 1 | Pulse: allocPage holds a granted page |
| allocFail | output | 1 | Pulse: no free page was available |
| allocPage | output | PAGE_W | Granted page index |
| refreshPeriodMs | output | PERIOD_W | Refresh period in ms that is safe for all occupied pages |

## Verification
Allocation is tried against pages loaded out of bin order, including two pages in one bin and an outlier. This separates longest-bin-first selection from head-of-list order within a bin, and it shows that the outlier is left out. Interleaved frees and re-allocations that empty and refill the weakest occupied bin make the period step down and back up across several bins. This separates tracking of the weakest occupied bin from tracking of the weakest bin ever loaded. Allocation on empty lists, before and after a full drain, shows that a failed request leaves later grants unchanged, and a reset in the middle of operation shows that every list is cleared.

// File: rtl/rba_pkg.sv
package rba_pkg;
  // Strobes from control to datapath; at most one is set per cycle.
  typedef struct packed {
    logic doInit;
    logic doFree;
    logic doAlloc;
    logic doFail;
  } rbaStrobe_t;
endpackage

// File: rtl/rba_ctrl.sv
module rba_ctrl
  import rba_pkg::*;
#(
  parameter int NUM_BINS = 10,
  parameter int BIN_W    = 4
) (
  input  logic                initValid,
  input  logic [BIN_W-1:0]    initBin,
  input  logic                freeValid,
  input  logic                allocReq,
  input  logic [NUM_BINS-1:0] binEmpty,
  output rbaStrobe_t          strobe,
  output logic [BIN_W-1:0]    popBin
);
  logic anyFree;
  logic allocSel;

  // Lowest-numbered non-empty bin holds the longest-retention free page.
  always_comb begin
    anyFree = 1'b0;
    popBin  = '0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (!anyFree && !binEmpty[b]) begin
        anyFree = 1'b1;
        popBin  = BIN_W'(b);
      end
    end
  end

  // Precedence: init, then free, then alloc.
  assign allocSel       = !initValid && !freeValid && allocReq;
  assign strobe.doInit  = initValid && (initBin < BIN_W'(NUM_BINS));
  assign strobe.doFree  = !initValid && freeValid;
  assign strobe.doAlloc = allocSel && anyFree;
  assign strobe.doFail  = allocSel && !anyFree;
endmodule

// File: rtl/rba_datapath.sv
module rba_datapath
  import rba_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_BINS  = 10,
  parameter int PAGE_W    = 4,
  parameter int BIN_W     = 4,
  parameter int PTR_W     = 5,
  parameter int CNT_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  rbaStrobe_t          strobe,
  input  logic [BIN_W-1:0]    popBin,
  input  logic [PAGE_W-1:0]   initPage,
  input  logic [BIN_W-1:0]    initBin,
  input  logic [PAGE_W-1:0]   freePage,
  output logic [NUM_BINS-1:0] binEmpty,
  output logic [NUM_BINS-1:0] occNonZero,
  output logic                allocGrant,
  output logic                allocFail,
  output logic [PAGE_W-1:0]   allocPage
);
  localparam logic [PTR_W-1:0] NIL = PTR_W'(NUM_PAGES);

  logic [PTR_W-1:0] headQ    [NUM_BINS];
  logic [PTR_W-1:0] nextQ    [NUM_PAGES];
  logic [BIN_W-1:0] pageBinQ [NUM_PAGES];
  logic [CNT_W-1:0] occQ     [NUM_BINS];

  logic              pushEn;
  logic [PAGE_W-1:0] pushPage;
  logic [BIN_W-1:0]  pushBin;
  logic [PAGE_W-1:0] popPage;

  assign pushEn   = strobe.doInit || strobe.doFree;
  assign pushPage = strobe.doInit ? initPage : freePage;
  assign pushBin  = strobe.doInit ? initBin : pageBinQ[freePage];
  assign popPage  = headQ[popBin][PAGE_W-1:0];

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_binFlags
    assign binEmpty[g]   = (headQ[g] == NIL);
    assign occNonZero[g] = (occQ[g] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BINS; b++) begin
        headQ[b] <= NIL;
        occQ[b]  <= '0;
      end
      for (int p = 0; p < NUM_PAGES; p++) begin
        nextQ[p]    <= NIL;
        pageBinQ[p] <= '0;
      end
      allocGrant <= 1'b0;
      allocFail  <= 1'b0;
      allocPage  <= '0;
    end else begin
      allocGrant <= strobe.doAlloc;
      allocFail  <= strobe.doFail;
      if (strobe.doAlloc) begin
        allocPage     <= popPage;
        headQ[popBin] <= nextQ[popPage];
        occQ[popBin]  <= occQ[popBin] + 1'b1;
      end
      if (pushEn) begin
        nextQ[pushPage] <= headQ[pushBin];
        headQ[pushBin]  <= PTR_W'(pushPage);
      end
      if (strobe.doInit) pageBinQ[pushPage] <= initBin;
      if (strobe.doFree) occQ[pushBin] <= occQ[pushBin] - 1'b1;
    end
  end
endmodule

// File: rtl/rba_period.sv
module rba_period #(
  parameter int NUM_BINS = 10,
  parameter int PERIOD_W = 16,
  parameter int MAX_MS   = 50000,
  parameter int STEP_MS  = 4700
) (
  input  logic [NUM_BINS-1:0] occNonZero,
  output logic [PERIOD_W-1:0] periodMs
);
  // Highest-numbered occupied bin wins: the last match in the loop.
  always_comb begin
    periodMs = PERIOD_W'(MAX_MS - STEP_MS);
    for (int b = 0; b < NUM_BINS; b++) begin
      if (occNonZero[b]) periodMs = PERIOD_W'(MAX_MS - (b + 1) * STEP_MS);
    end
  end
endmodule

// File: rtl/retention_page_alloc.sv
module retention_page_alloc
  import rba_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_BINS  = 10,
  parameter int MAX_MS    = 50000,
  parameter int STEP_MS   = 4700,
  parameter int PERIOD_W  = 16,
  localparam int PAGE_W   = $clog2(NUM_PAGES),
  localparam int BIN_W    = $clog2(NUM_BINS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                initValid,
  input  logic [PAGE_W-1:0]   initPage,
  input  logic [BIN_W-1:0]    initBin,
  input  logic                freeValid,
  input  logic [PAGE_W-1:0]   freePage,
  input  logic                allocReq,
  output logic                allocGrant,
  output logic                allocFail,
  output logic [PAGE_W-1:0]   allocPage,
  output logic [PERIOD_W-1:0] refreshPeriodMs
);
  localparam int PTR_W = $clog2(NUM_PAGES + 1);
  localparam int CNT_W = $clog2(NUM_PAGES + 1);

  rbaStrobe_t          strobe;
  logic [BIN_W-1:0]    popBin;
  logic [NUM_BINS-1:0] binEmpty;
  logic [NUM_BINS-1:0] occNonZero;

  rba_ctrl #(.NUM_BINS(NUM_BINS), .BIN_W(BIN_W)) i_ctrl (
    .initValid(initValid), .initBin(initBin), .freeValid(freeValid),
    .allocReq(allocReq), .binEmpty(binEmpty), .strobe(strobe), .popBin(popBin)
  );

  rba_datapath #(
    .NUM_PAGES(NUM_PAGES), .NUM_BINS(NUM_BINS), .PAGE_W(PAGE_W),
    .BIN_W(BIN_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .popBin(popBin),
    .initPage(initPage), .initBin(initBin), .freePage(freePage),
    .binEmpty(binEmpty), .occNonZero(occNonZero),
    .allocGrant(allocGrant), .allocFail(allocFail), .allocPage(allocPage)
  );

  rba_period #(
    .NUM_BINS(NUM_BINS), .PERIOD_W(PERIOD_W), .MAX_MS(MAX_MS), .STEP_MS(STEP_MS)
  ) i_period (
    .occNonZero(occNonZero), .periodMs(refreshPeriodMs)
  );
endmodule

// File: rtl/retention_page_alloc_chk.sv
module retention_page_alloc_chk #(
  parameter int PAGE_W   = 4,
  parameter int PERIOD_W = 16,
  parameter int NUM_BINS = 10,
  parameter int MAX_MS   = 50000,
  parameter int STEP_MS  = 4700
) (
  input logic                clk,
  input logic                rstN,
  input logic                initValid,
  input logic                freeValid,
  input logic                allocReq,
  input logic                allocGrant,
  input logic                allocFail,
  input logic [PAGE_W-1:0]   allocPage,
  input logic [PERIOD_W-1:0] refreshPeriodMs
);
  assert_grant_fail_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(allocGrant && allocFail));

  assert_resp_has_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant || allocFail) |-> $past(allocReq));

  assert_req_answered_R4: assert property (@(posedge clk) disable iff (!rstN)
    (allocReq && !initValid && !freeValid) |=> (allocGrant || allocFail));

  assert_fail_keeps_period_R6: assert property (@(posedge clk) disable iff (!rstN)
    allocFail |-> $stable(refreshPeriodMs));

  assert_grant_no_raise_R10: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> (refreshPeriodMs <= $past(refreshPeriodMs)));

  assert_free_no_lower_R10: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && !initValid) |=> (refreshPeriodMs >= $past(refreshPeriodMs)));

  assert_period_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refreshPeriodMs <= PERIOD_W'(MAX_MS - STEP_MS)) &&
    (refreshPeriodMs >= PERIOD_W'(MAX_MS - NUM_BINS * STEP_MS)));
endmodule

bind retention_page_alloc retention_page_alloc_chk #(
  .PAGE_W(PAGE_W), .PERIOD_W(PERIOD_W), .NUM_BINS(NUM_BINS),
  .MAX_MS(MAX_MS), .STEP_MS(STEP_MS)
) i_chk (
  .clk(clk), .rstN(rstN), .initValid(initValid), .freeValid(freeValid),
  .allocReq(allocReq), .allocGrant(allocGrant), .allocFail(allocFail),
  .allocPage(allocPage), .refreshPeriodMs(refreshPeriodMs)
);

// File: tb/test_retention_page_alloc.sv
module test_retention_page_alloc;
  localparam int CLK_HALF = 5;
  localparam logic [1:0] OP_INIT = 2'd0, OP_ALLOC = 2'd1, OP_FREE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  page;
    logic [3:0]  bin;
    logic        expG;
    logic        expF;
    logic [3:0]  expPage;
    logic [15:0] expPer;
  } vec_t;

  localparam int NV = 27;
  // Bin bounds: b0 45300, b2 35900, b5 21800, b9 3000; bin 10 marks an outlier.
  localparam vec_t VECS [NV] = '{
    '{OP_INIT,  4'd0, 4'd2,  1'b0, 1'b0, 4'd0, 16'd45300}, // R2
    '{OP_INIT,  4'd1, 4'd0,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_INIT,  4'd2, 4'd0,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_INIT,  4'd3, 4'd9,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_INIT,  4'd4, 4'd10, 1'b0, 1'b0, 4'd0, 16'd45300}, // R3 outlier
    '{OP_INIT,  4'd5, 4'd5,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd2, 16'd45300}, // R4 R5
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd1, 16'd45300},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd0, 16'd35900}, // R8
    '{OP_FREE,  4'd1, 4'd0,  1'b0, 1'b0, 4'd0, 16'd35900},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd1, 16'd35900}, // R7
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd5, 16'd21800},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd3, 16'd3000},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b0, 1'b1, 4'd0, 16'd3000},  // R3 R6
    '{OP_FREE,  4'd3, 4'd0,  1'b0, 1'b0, 4'd0, 16'd21800}, // R8 R10
    '{OP_FREE,  4'd5, 4'd0,  1'b0, 1'b0, 4'd0, 16'd35900},
    '{OP_FREE,  4'd0, 4'd0,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd0, 16'd35900}, // R7
    '{OP_FREE,  4'd2, 4'd0,  1'b0, 1'b0, 4'd0, 16'd35900},
    '{OP_FREE,  4'd1, 4'd0,  1'b0, 1'b0, 4'd0, 16'd35900},
    '{OP_FREE,  4'd0, 4'd0,  1'b0, 1'b0, 4'd0, 16'd45300},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd1, 16'd45300}, // R5 R7
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd2, 16'd45300},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd0, 16'd35900},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd5, 16'd21800},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b1, 1'b0, 4'd3, 16'd3000},
    '{OP_ALLOC, 4'd0, 4'd0,  1'b0, 1'b1, 4'd0, 16'd3000}   // R6
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initValid = 1'b0, freeValid = 1'b0, allocReq = 1'b0;
  logic [3:0] initPage = '0, freePage = '0;
  logic [3:0] initBin = '0;
  logic allocGrant, allocFail;
  logic [3:0] allocPage;
  logic [15:0] refreshPeriodMs;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #CLK_HALF clk = ~clk;

  retention_page_alloc i_retention_page_alloc (
    .clk(clk), .rstN(rstN), .initValid(initValid), .initPage(initPage),
    .initBin(initBin), .freeValid(freeValid), .freePage(freePage),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocFail(allocFail),
    .allocPage(allocPage), .refreshPeriodMs(refreshPeriodMs)
  );

  task automatic check(input string req, input logic g, input logic f,
                       input logic [3:0] pg, input logic [15:0] per);
    nChecks++;
    if (allocGrant !== g || allocFail !== f || refreshPeriodMs !== per ||
        (g && allocPage !== pg)) begin
      nFails++;
      $display("FAIL %s: got grant=%b fail=%b page=%0d period=%0d, expected grant=%b fail=%b page=%0d period=%0d",
               req, allocGrant, allocFail, allocPage, refreshPeriodMs, g, f, pg, per);
    end
  endtask

  // Drive one operation for one cycle, then sample the registered response.
  task automatic doOp(input logic [1:0] op, input logic [3:0] pg, input logic [3:0] bn);
    @(negedge clk);
    initValid = (op == OP_INIT);
    allocReq  = (op == OP_ALLOC);
    freeValid = (op == OP_FREE);
    initPage = pg; freePage = pg; initBin = bn;
    @(negedge clk);
    initValid = 1'b0; allocReq = 1'b0; freeValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    check("R1 reset state", 1'b0, 1'b0, 4'd0, 16'd45300);
    doOp(OP_ALLOC, 4'd0, 4'd0);
    check("R1 empty after reset", 1'b0, 1'b1, 4'd0, 16'd45300);

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, VECS[i].page, VECS[i].bin);
      check($sformatf("R4/R5/R7/R8 vector %0d", i), VECS[i].expG, VECS[i].expF,
            VECS[i].expPage, VECS[i].expPer);
      if (i == 12) begin
        // R9: the response of vector 12 is a single-cycle pulse
        @(negedge clk);
        check("R9 pulse ends", 1'b0, 1'b0, 4'd0, 16'd3000);
      end
    end

    // R2: bin 8 lower bound is 7700 ms
    doOp(OP_INIT, 4'd7, 4'd8);
    check("R2 init bin 8", 1'b0, 1'b0, 4'd0, 16'd3000);
    doOp(OP_FREE, 4'd3, 4'd0);
    check("R8 bin 9 released", 1'b0, 1'b0, 4'd0, 16'd21800);
    doOp(OP_FREE, 4'd5, 4'd0);
    check("R8 bin 5 released", 1'b0, 1'b0, 4'd0, 16'd35900);
    doOp(OP_ALLOC, 4'd0, 4'd0);
    check("R4 longest bin first", 1'b1, 1'b0, 4'd5, 16'd21800);
    doOp(OP_ALLOC, 4'd0, 4'd0);
    check("R2 bin 8 bound", 1'b1, 1'b0, 4'd7, 16'd7700);

    // R1: reset mid-operation clears every list and occupancy
    doReset();
    check("R1 period after reset", 1'b0, 1'b0, 4'd0, 16'd45300);
    doOp(OP_ALLOC, 4'd0, 4'd0);
    check("R1 lists cleared", 1'b0, 1'b1, 4'd0, 16'd45300);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 2 * CLK_HALF);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule